// File: doc/BRIEF.md
# Predicated SIMD Saturating Variable Shifter

This block applies a per-lane variable shift to a packed vector of signed integers. Each lane's shift count is the signed value held in the matching lane of a second packed vector. The sign of the count sets the direction: a zero or positive count shifts left, and a negative count shifts right arithmetically by its magnitude. A left shift that leaves the lane's signed range clips to the nearest limit. A byte-granular predicate masks the lanes, and a masked lane returns the first operand's lane unchanged.

All lanes in one operation share one element width, chosen by a 2-bit size code. The vector width is a parameter. An operation is accepted in the cycle `in_valid` is high, and its result is registered. A per-operation flag reports whether any active lane clipped. The flag does not accumulate across operations.

Top module: `simd_satshift`

## Requirements
- R1: The size code `in_size` sets the element width N. Code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The vector splits into VEC_W/N lanes, and lane i occupies bits [i*N +: N].
- R2: In an active lane, a count that is zero or positive shifts the element left. A negative count shifts it right arithmetically by the count's magnitude. A right shift truncates and does not round.
- R3: An active left-shift result above 2^(N-1)-1 becomes 2^(N-1)-1. A result below -2^(N-1) becomes -2^(N-1).
- R4: A lane is active when the predicate bit of its lowest byte (bit i*N/8) is 1. The other predicate bits in that lane's byte group are ignored. An inactive lane outputs the first operand's lane unchanged.
- R5: A right shift by N or more gives 0 for a non-negative element and -1 for a negative element.
- R6: A left shift by N or more of a nonzero element gives the positive limit if the element is positive, and the negative limit if it is negative. A zero element gives zero for any count.
- R7: `out_sat` is 1 exactly when at least one active lane of the operation clipped. Inactive lanes never set it, and it reflects only the most recent operation.
- R8: `out_valid` is high in the cycle after each cycle in which `in_valid` is high. When `in_valid` is low, `out_vec` and `out_sat` hold their previous values.
- R9: After a synchronous reset, `out_valid`, `out_vec` and `out_sat` are 0.
- R10: The most negative count value of a lane, such as -128 at 8 bits, acts as a right shift far beyond the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_size | input | 2 | Element size code |
| in_vec | input | VEC_W | First operand, and the pass-through source for inactive lanes |
| in_cnt | input | VEC_W | Per-lane signed shift counts |
| in_pred | input | VEC_W/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result strobe |
| out_vec | output | VEC_W | Registered result |
| out_sat | output | 1 | Any active lane clipped in this operation |

## Verification
The bench concentrates on the edges of the count range. These are a count equal to N, counts far beyond N, and the most negative count. A design that wraps the count or fails to clamp it would shift by a small, wrong amount at these values, or would leave a result unsaturated. The bench also sets predicates whose upper bits disagree with the lowest bit of a lane. A design that decodes the wrong bit would then pass through, or modify, the wrong lanes. Further cases target a zero element under a huge left count, negative elements under huge right counts, and a lane that would clip while masked. A wrong design would produce a spurious limit, a 0 in place of -1, or a false `out_sat`.

// File: rtl/satshift_pkg.sv
package satshift_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } elem_size_e;

    localparam int NUM_SIZES = 4;

    function automatic int elem_bits(input int code);
        return 8 << code;
    endfunction

endpackage

// File: rtl/satshift_lane.sv
module satshift_lane #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] elem,
    input  logic [EW-1:0] cnt,
    input  logic          active,
    output logic [EW-1:0] res,
    output logic          sat
);
    localparam int AW = $clog2(EW) + 1;
    localparam int WW = 2 * EW + 1;
    localparam logic signed [WW-1:0] MAXW = (WW'(1) <<< (EW - 1)) - WW'(1);
    localparam logic signed [WW-1:0] MINW = -MAXW - WW'(1);
    localparam logic [EW-1:0] MAXV = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] MINV = {1'b1, {(EW-1){1'b0}}};

    logic signed [EW:0]   cnt_ext;
    logic signed [EW:0]   cnt_neg;
    logic                 go_left;
    logic [AW-1:0]        left_amt;
    logic [AW-1:0]        right_amt;
    logic signed [WW-1:0] elem_ext;
    logic signed [WW-1:0] shl;
    logic [EW-1:0]        shr;
    logic                 over_hi;
    logic                 over_lo;

    always_comb begin
        cnt_ext   = {cnt[EW-1], cnt};
        cnt_neg   = -cnt_ext;
        go_left   = !cnt[EW-1];
        // clamp counts so that anything past the width behaves like width
        left_amt  = (cnt_ext > EW) ? AW'(EW) : AW'(cnt_ext);
        right_amt = (cnt_neg > EW - 1) ? AW'(EW - 1) : AW'(cnt_neg);
        elem_ext  = {{(EW+1){elem[EW-1]}}, elem};
        shl       = elem_ext <<< left_amt;
        shr       = $signed(elem) >>> right_amt;
        over_hi   = shl > MAXW;
        over_lo   = shl < MINW;
        if (!active)      res = elem;
        else if (!go_left) res = shr;
        else if (over_hi) res = MAXV;
        else if (over_lo) res = MINV;
        else              res = shl[EW-1:0];
        sat = active && go_left && (over_hi || over_lo);
    end
endmodule

// File: rtl/satshift_group.sv
module satshift_group #(
    parameter int VEC_W = 128,
    parameter int EW    = 8
) (
    input  logic [VEC_W-1:0]   vec,
    input  logic [VEC_W-1:0]   cnt,
    input  logic [VEC_W/8-1:0] pred,
    output logic [VEC_W-1:0]   res,
    output logic               sat_any
);
    localparam int LANES = VEC_W / EW;
    localparam int BPL   = EW / 8;

    logic [LANES-1:0] lane_sat;
    logic [LANES-1:0] lane_act;
    logic [VEC_W/8-1:0] unused_pred;

    assign unused_pred = pred;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_act[i] = pred[i*BPL];
        satshift_lane #(.EW(EW)) u_lane (
            .elem   (vec[i*EW +: EW]),
            .cnt    (cnt[i*EW +: EW]),
            .active (lane_act[i]),
            .res    (res[i*EW +: EW]),
            .sat    (lane_sat[i])
        );
    end

    assign sat_any = |lane_sat;
endmodule

// File: rtl/simd_satshift.sv
module simd_satshift
    import satshift_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_size,
    input  logic [VEC_W-1:0]   in_vec,
    input  logic [VEC_W-1:0]   in_cnt,
    input  logic [VEC_W/8-1:0] in_pred,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_vec,
    output logic               out_sat
);
    logic [VEC_W-1:0] res_by [NUM_SIZES];
    logic             sat_by [NUM_SIZES];
    logic [VEC_W-1:0] res_sel;
    logic             sat_sel;
    elem_size_e       size_q;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_width
        satshift_group #(.VEC_W(VEC_W), .EW(elem_bits(s))) u_group (
            .vec     (in_vec),
            .cnt     (in_cnt),
            .pred    (in_pred),
            .res     (res_by[s]),
            .sat_any (sat_by[s])
        );
    end

    always_comb begin
        size_q  = elem_size_e'(in_size);
        res_sel = res_by[size_q];
        sat_sel = sat_by[size_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            out_sat   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec <= res_sel;
                out_sat <= sat_sel;
            end
        end
    end
endmodule

// File: rtl/satshift_checker.sv
module satshift_checker #(
    parameter int VEC_W = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [1:0]         in_size,
    input logic [VEC_W-1:0]   in_vec,
    input logic [VEC_W-1:0]   in_cnt,
    input logic [VEC_W/8-1:0] in_pred,
    input logic               out_valid,
    input logic [VEC_W-1:0]   out_vec,
    input logic               out_sat
);
    a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_vec) && $stable(out_sat)));
    a_r9_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0 && !out_sat));
    a_r7_no_active: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pred == '0) |=> (!out_sat && out_vec == $past(in_vec)));
    a_r2_zero_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cnt == '0) |=> (!out_sat && out_vec == $past(in_vec)));

    for (genvar b = 0; b < VEC_W/8; b++) begin : g_byte
        a_r4_byte_pass: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_size == 2'd0 && !in_pred[b]) |=>
            (out_vec[b*8 +: 8] == $past(in_vec[b*8 +: 8])));
    end
endmodule

bind simd_satshift satshift_checker #(.VEC_W(VEC_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_size   (in_size),
    .in_vec    (in_vec),
    .in_cnt    (in_cnt),
    .in_pred   (in_pred),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_sat   (out_sat)
);

// File: tb/simd_satshift_bench.sv
`timescale 1ns/1ps
module simd_satshift_bench;
    localparam int VW = 128;
    localparam int PW = VW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_size = '0;
    logic [VW-1:0] in_vec = '0;
    logic [VW-1:0] in_cnt = '0;
    logic [PW-1:0] in_pred = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic          out_sat;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    simd_satshift #(.VEC_W(VW)) u_simd_satshift (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_vec(in_vec), .in_cnt(in_cnt), .in_pred(in_pred),
        .out_valid(out_valid), .out_vec(out_vec), .out_sat(out_sat)
    );

    task automatic check(input string req, input logic [VW-1:0] got_v, input logic [VW-1:0] exp_v,
                         input logic got_s, input logic exp_s);
        checks++;
        if (got_v !== exp_v || got_s !== exp_s) begin
            errors++;
            $display("FAIL %s vec=%h sat=%0b expected vec=%h sat=%0b", req, got_v, got_s, exp_v, exp_s);
        end
    endtask

    // independent model of the requirements
    task automatic model(input logic [VW-1:0] v, input logic [VW-1:0] c, input logic [PW-1:0] p,
                         input logic [1:0] sz, output logic [VW-1:0] r, output logic s);
        int ew = 8 << sz;
        logic signed [129:0] one = 130'sd1;
        logic signed [129:0] mx = (one <<< (ew - 1)) - 1;
        logic signed [129:0] mn = -(one <<< (ew - 1));
        logic [129:0] lm = (130'd1 << ew) - 1;
        r = '0;
        s = 1'b0;
        for (int ln = 0; ln < VW / ew; ln++) begin
            logic signed [129:0] e = $signed(130'((v >> (ln * ew))) & lm);
            logic signed [129:0] k = $signed(130'((c >> (ln * ew))) & lm);
            logic signed [129:0] q;
            if (e[ew-1]) e = e - (one <<< ew);
            if (k[ew-1]) k = k - (one <<< ew);
            if (!p[ln * ew / 8]) q = e;
            else if (k >= 0) begin
                int a = (k > ew) ? ew : int'(k);
                q = e <<< a;
                if (q > mx) begin q = mx; s = 1'b1; end
                else if (q < mn) begin q = mn; s = 1'b1; end
            end else if (-k >= ew) q = (e < 0) ? -one : 130'sd0;
            else q = e >>> int'(-k);
            r = r | VW'((130'(q) & lm) << (ln * ew));
        end
    endtask

    function automatic logic [VW-1:0] rep(input logic [63:0] val, input logic [1:0] sz);
        int ew = 8 << sz;
        logic [VW-1:0] o = '0;
        for (int i = 0; i < VW / ew; i++)
            o = o | (VW'(val & ((65'd1 << ew) - 1)) << (i * ew));
        return o;
    endfunction

    task automatic op(input string req, input logic [VW-1:0] v, input logic [VW-1:0] c,
                      input logic [PW-1:0] p, input logic [1:0] sz);
        logic [VW-1:0] ev;
        logic es;
        model(v, c, p, sz, ev, es);
        @(negedge clk);
        in_valid = 1'b1; in_vec = v; in_cnt = c; in_pred = p; in_size = sz;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R8 out_valid=%0b expected 1", out_valid);
        end
        check(req, out_vec, ev, out_sat, es);
    endtask

    task automatic t_reset;
        check("R9", out_vec, '0, out_sat, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 out_valid=%0b expected 0", out_valid);
        end
    endtask

    task automatic t_widths;
        for (int sz = 0; sz < 4; sz++) begin
            for (int n = 0; n < 6; n++) begin
                logic [VW-1:0] v = {$urandom, $urandom, $urandom, $urandom};
                logic [VW-1:0] c = '0;
                int ew = 8 << sz;
                for (int i = 0; i < VW / ew; i++) begin
                    int k = int'($urandom_range(0, 2 * ew + 2)) - (ew + 1);
                    c = c | (VW'(64'(k) & ((65'd1 << ew) - 1)) << (i * ew));
                end
                op("R1 R2", v, c, '1, 2'(sz));
            end
        end
    endtask

    task automatic t_saturate;
        op("R3", rep(64'h7F, 0), rep(64'h1, 0), '1, 2'd0);
        check("R3 limit", out_vec, rep(64'h7F, 0), out_sat, 1'b1);
        op("R3", rep(64'h8001, 1), rep(64'h2, 1), '1, 2'd1);
        check("R3 neg limit", out_vec, rep(64'h8000, 1), out_sat, 1'b1);
        op("R3", rep(64'h20, 0), rep(64'h1, 0), '1, 2'd0);
        check("R3 in range", out_vec, rep(64'h40, 0), out_sat, 1'b0);
    endtask

    task automatic t_predicate;
        // 32-bit lanes: lowest byte bit clear but upper bits set -> inactive
        op("R4", rep(64'h1, 2), rep(64'h4, 2), 16'h0E1E, 2'd2);
        check("R4 grouped", out_vec, {32'h1, 32'h1, 32'h10, 32'h1}, out_sat, 1'b0);
        op("R4", rep(64'h55, 0), rep(64'h1, 0), 16'h0000, 2'd0);
        check("R4 none active", out_vec, rep(64'h55, 0), out_sat, 1'b0);
    endtask

    task automatic t_far_right;
        op("R5", rep(64'hFFFF_FFF0, 2), rep(64'hFFFF_FFE0, 2), '1, 2'd2);
        check("R5 neg", out_vec, rep(64'hFFFF_FFFF, 2), out_sat, 1'b0);
        op("R5", rep(64'h7FFF, 1), rep(64'hFF00, 1), '1, 2'd1);
        check("R5 pos", out_vec, '0, out_sat, 1'b0);
    endtask

    task automatic t_far_left;
        op("R6", rep(64'h3, 3), rep(64'h40, 3), '1, 2'd3);
        check("R6 pos", out_vec, rep(64'h7FFF_FFFF_FFFF_FFFF, 3), out_sat, 1'b1);
        op("R6", rep(64'hFF, 0), rep(64'h7F, 0), '1, 2'd0);
        check("R6 neg", out_vec, rep(64'h80, 0), out_sat, 1'b1);
        op("R6", '0, rep(64'h7F, 0), '1, 2'd0);
        check("R6 zero", out_vec, '0, out_sat, 1'b0);
    endtask

    task automatic t_min_count;
        op("R10", rep(64'h85, 0), rep(64'h80, 0), '1, 2'd0);
        check("R10 neg", out_vec, rep(64'hFF, 0), out_sat, 1'b0);
        op("R10", rep(64'h45, 0), rep(64'h80, 0), '1, 2'd0);
        check("R10 pos", out_vec, '0, out_sat, 1'b0);
    endtask

    task automatic t_flag;
        // lane 0 would clip but is masked; lane 1 shifts within range
        op("R7", {112'h0, 8'h01, 8'h7F}, {112'h0, 8'h01, 8'h01}, 16'h0002, 2'd0);
        check("R7 masked clip", out_vec, {112'h0, 8'h02, 8'h7F}, out_sat, 1'b0);
        op("R7", rep(64'h1, 0), rep(64'h1, 0), '1, 2'd0);
        check("R7 cleared", out_vec, rep(64'h2, 0), out_sat, 1'b0);
    endtask

    task automatic t_hold;
        logic [VW-1:0] keep = out_vec;
        logic ks = out_sat;
        @(negedge clk);
        in_vec = '1; in_cnt = rep(64'h3, 0);
        @(negedge clk);
        @(negedge clk);
        check("R8 hold", out_vec, keep, out_sat, ks);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 idle out_valid=%0b expected 0", out_valid);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_widths();
        t_saturate();
        t_predicate();
        t_far_right();
        t_far_left();
        t_min_count();
        t_flag();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule